// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block keeps six 32-bit event counters for a processor core. Every clock cycle the core reports how many instructions it retired (0 to 4), whether a cycle tick occurred and the state of its run latch. Two control registers decide which counters run and what they count. The first control register holds freeze bits, overflow-enable bits and an interrupt enable. The second holds one 8-bit event code for each of counters 1 to 4.

Counters 5 and 6 have fixed events. Counters 1 to 4 decode their own event codes into instruction counting, cycle counting or idle. When a counter's overflow enable is set and an update reaches the sign-bit threshold, the counter saturates at that threshold and raises a per-counter overflow flag. If the interrupt enable is set, an overflow also raises an interrupt request.

Software reads and writes all eight registers through one address/data port.

Top module: `pmc_bank`

## Requirements
- R1: While control-0 bit 0 (global freeze) is set, none of the six counters changes except by a software write.
- R2: While control-0 bit 1 is set, or while control-1 is entirely zero, counters 1 to 4 do not change except by a software write.
- R3: While control-0 bit 2 is set, counters 5 and 6 do not change except by a software write. While it is clear, counter 5 adds the retired-instruction count and counter 6 adds one per cycle tick.
- R4: Counter 1 takes its event code from control-1 bits [31:24]. Codes 0x02 and 0xFE count instructions, codes 0x1E and 0xF0 count cycle ticks, and every other code leaves it idle.
- R5: Counters 2 and 3 take their codes from control-1 bits [23:16] and [15:8]. Code 0x02 counts instructions, code 0x1E counts cycle ticks, and every other code leaves them idle.
- R6: Counter 4 takes its code from control-1 bits [7:0]. Code 0x02 counts instructions, code 0xFA counts instructions only in cycles where run_latch is 1, code 0x1E counts cycle ticks, and every other code leaves it idle.
- R7: When a nonzero increment makes a counter's sum 0x80000000 or more and its overflow enable is set, the counter becomes exactly 0x80000000 and its bit in ovf_flags is 1 in the following cycle. With the enable clear, the counter wraps modulo 2^32 and raises no flag.
- R8: Counter 1's overflow enable is control-0 bit 3. Counters 2 to 6 share control-0 bit 4 as their overflow enable.
- R9: irq is 1 in the cycle after an overflow only if control-0 bit 5 was set in the overflow cycle. Otherwise it is 0.
- R10: An instruction-counting counter adds the whole retired-instruction count (0 to 4) in one update. A cycle-counting counter adds 1 per tick.
- R11: A software write to a counter replaces its value and overrides any increment in the same cycle. A control write governs counting from the next cycle on.
- R12: Addresses 0 to 5 select counters 1 to 6, address 6 selects control-0 and address 7 selects control-1. reg_rdata shows, one cycle later, the addressed register's value from before that edge. Reset clears every register and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_cnt | input | 3 | Instructions retired this cycle (0 to 4) |
| cyc_tick | input | 1 | Cycle event this cycle |
| run_latch | input | 1 | Core run-latch state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ovf_flags | output | 6 | Per-counter overflow event, one cycle after the update |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is an increment that lands exactly on, or jumps past, the sign-bit threshold. This has to happen under each combination of counter-1 enable, shared enable and interrupt enable, and sometimes in the same cycle as a write. The bench gets there by writing counters to values just below 0x80000000 (and just below 2^32 for the wrap case) and then driving 4-instruction bursts. A cycle-accurate model in the bench compares every read, flag and interrupt in every cycle. All 256 event codes are also swept across counters 1 to 4, with the run latch toggling, so that every decode branch is covered.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {EV_IDLE = 2'd0, EV_INST = 2'd1, EV_CYC = 2'd2} ev_kind_e;

  localparam int unsigned C0_FRZ_ALL = 0;
  localparam int unsigned C0_FRZ_SEL = 1;
  localparam int unsigned C0_FRZ_FIX = 2;
  localparam int unsigned C0_OVE_ONE = 3;
  localparam int unsigned C0_OVE_OTH = 4;
  localparam int unsigned C0_IRQ_EN  = 5;

  localparam logic [7:0] CODE_INST     = 8'h02;
  localparam logic [7:0] CODE_CYC      = 8'h1E;
  localparam logic [7:0] CODE_INST_ALT = 8'hFE;
  localparam logic [7:0] CODE_CYC_ALT  = 8'hF0;
  localparam logic [7:0] CODE_RUN_INST = 8'hFA;
endpackage

// File: rtl/pmc_event_decode.sv
module pmc_event_decode
  import pmc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [7:0] code,
  input  logic       run_latch,
  output ev_kind_e   kind
);
  generate
    if (IDX == 0) begin : g_first
      always_comb begin
        if (code == CODE_INST || code == CODE_INST_ALT)     kind = EV_INST;
        else if (code == CODE_CYC || code == CODE_CYC_ALT)  kind = EV_CYC;
        else                                                kind = EV_IDLE;
      end
    end else if (IDX == 3) begin : g_fourth
      always_comb begin
        if (code == CODE_INST)                                 kind = EV_INST;
        else if (code == CODE_RUN_INST && run_latch)           kind = EV_INST;
        else if (code == CODE_CYC)                             kind = EV_CYC;
        else                                                   kind = EV_IDLE;
      end
    end else if (IDX == 4) begin : g_fixed_inst
      assign kind = EV_INST;
    end else if (IDX == 5) begin : g_fixed_cyc
      assign kind = EV_CYC;
    end else begin : g_plain
      always_comb begin
        if (code == CODE_INST)     kind = EV_INST;
        else if (code == CODE_CYC) kind = EV_CYC;
        else                       kind = EV_IDLE;
      end
    end
  endgenerate
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INST_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_kind_e          kind,
  input  logic              frozen,
  input  logic [INST_W-1:0] inst_cnt,
  input  logic              cyc_tick,
  input  logic              ovf_en,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  value,
  output logic              ovf_hit
);
  localparam logic [CNT_W:0] THRESH = (CNT_W+1)'(1) << (CNT_W-1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] delta;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    delta = '0;
    if (!frozen) begin
      if (kind == EV_INST)     delta = CNT_W'(inst_cnt);
      else if (kind == EV_CYC) delta = CNT_W'(cyc_tick);
    end
    sum     = {1'b0, cnt_q} + {1'b0, delta};
    ovf_hit = !wr_en && (delta != '0) && ovf_en && (sum >= THRESH);
    if (wr_en)        cnt_d = wr_data;
    else if (ovf_hit) cnt_d = THRESH[CNT_W-1:0];
    else              cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign value = cnt_q;

  // R7: an overflow leaves the counter parked exactly at the threshold
  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_hit |=> (cnt_q == THRESH[CNT_W-1:0]));

  // R11: a write wins over any increment
  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt_q == $past(wr_data)));

  // R10: an idle or frozen counter without a write holds its value
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (frozen || kind == EV_IDLE)) |=> $stable(cnt_q));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int INST_W  = 3,
  parameter int NUM_CTR = 6,
  parameter int NUM_SEL = 4,
  parameter int ADDR_W  = $clog2(NUM_CTR + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INST_W-1:0]  inst_cnt,
  input  logic               cyc_tick,
  input  logic               run_latch,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  output logic [NUM_CTR-1:0] ovf_flags,
  output logic               irq
);
  localparam int CODE_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_C0 = ADDR_W'(NUM_CTR);
  localparam logic [ADDR_W-1:0] ADDR_C1 = ADDR_W'(NUM_CTR + 1);

  logic [CNT_W-1:0]         ctrl0_q, ctrl1_q;
  logic [CNT_W-1:0]         cnt [NUM_CTR];
  logic [NUM_CTR*CNT_W-1:0] cnt_flat;
  logic [NUM_CTR-1:0]       hit;
  logic                     sel_idle;

  assign sel_idle = (ctrl1_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_C0) ctrl0_q <= reg_wdata;
      if (reg_addr == ADDR_C1) ctrl1_q <= reg_wdata;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic [CODE_W-1:0] code;
      ev_kind_e          kind;
      logic              frozen;
      logic              ove;
      logic              wr;

      if (i < NUM_SEL) begin : g_sel
        assign code   = ctrl1_q[CODE_W*(NUM_SEL-1-i) +: CODE_W];
        assign frozen = ctrl0_q[C0_FRZ_ALL] | ctrl0_q[C0_FRZ_SEL] | sel_idle;
      end else begin : g_fix
        assign code   = '0;
        assign frozen = ctrl0_q[C0_FRZ_ALL] | ctrl0_q[C0_FRZ_FIX];
      end

      if (i == 0) begin : g_ove_one
        assign ove = ctrl0_q[C0_OVE_ONE];
      end else begin : g_ove_oth
        assign ove = ctrl0_q[C0_OVE_OTH];
      end

      assign wr = reg_we && (reg_addr == ADDR_W'(i));

      pmc_event_decode #(.IDX(i)) u_dec (
        .code      (code),
        .run_latch (run_latch),
        .kind      (kind)
      );

      pmc_counter #(.CNT_W(CNT_W), .INST_W(INST_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .frozen   (frozen),
        .inst_cnt (inst_cnt),
        .cyc_tick (cyc_tick),
        .ovf_en   (ove),
        .wr_en    (wr),
        .wr_data  (reg_wdata),
        .value    (cnt[i]),
        .ovf_hit  (hit[i])
      );

      assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      ovf_flags <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_addr == ADDR_C0)      reg_rdata <= ctrl0_q;
      else if (reg_addr == ADDR_C1) reg_rdata <= ctrl1_q;
      else                          reg_rdata <= cnt[reg_addr[$clog2(NUM_CTR)-1:0]];
      ovf_flags <= hit;
      irq       <= (|hit) & ctrl0_q[C0_IRQ_EN];
    end
  end

  // R1: global freeze holds every counter when nothing is written
  p_freeze_all_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl0_q[C0_FRZ_ALL] && !reg_we) |=> $stable(cnt_flat));

  // R2: an all-zero select register idles the selectable counters
  p_sel_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_idle && !reg_we) |=> $stable(cnt_flat[NUM_SEL*CNT_W-1:0]));

  // R9: an interrupt needs the enable and at least one flag
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ctrl0_q[C0_IRQ_EN]) && (ovf_flags != '0)));
endmodule

// File: tb/pmc_bank_tb.sv
module pmc_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [32:0] THR = 33'h0_8000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  inst_cnt;
  logic        cyc_tick, run_latch, reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [5:0]  ovf_flags;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] m_cnt [6];
  logic [31:0] m_c0, m_c1;
  logic [5:0]  m_flags;
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_bank u_dut (
    .clk(clk), .rst(rst), .inst_cnt(inst_cnt), .cyc_tick(cyc_tick),
    .run_latch(run_latch), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flags(ovf_flags), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 0 idle, 1 instructions, 2 cycles
  function automatic int kind_of(int i, logic [7:0] c, logic rl);
    case (i)
      0: return (c == 8'h02 || c == 8'hFE) ? 1 : (c == 8'h1E || c == 8'hF0) ? 2 : 0;
      1, 2: return (c == 8'h02) ? 1 : (c == 8'h1E) ? 2 : 0;
      3: return (c == 8'h02 || (c == 8'hFA && rl)) ? 1 : (c == 8'h1E) ? 2 : 0;
      4: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic step(string tag, logic [2:0] ic, logic ct, logic rl,
                      logic we, logic [2:0] a, logic [31:0] wd);
    logic [31:0] exp_rd;
    logic [5:0]  nf;
    @(negedge clk);
    inst_cnt = ic; cyc_tick = ct; run_latch = rl;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    exp_rd = (a < 3'd6) ? m_cnt[a] : (a == 3'd6) ? m_c0 : m_c1;
    nf = '0;
    for (int i = 0; i < 6; i++) begin
      logic        frz;
      logic [7:0]  code;
      logic [31:0] d;
      logic [32:0] s;
      logic        en;
      code = (i < 4) ? m_c1[8*(3-i) +: 8] : 8'h00;
      frz  = m_c0[0] | ((i < 4) ? (m_c0[1] | (m_c1 == 0)) : m_c0[2]);
      case (kind_of(i, code, rl))
        1: d = {29'd0, ic};
        2: d = {31'd0, ct};
        default: d = 0;
      endcase
      if (frz) d = 0;
      en = (i == 0) ? m_c0[3] : m_c0[4];
      s  = {1'b0, m_cnt[i]} + {1'b0, d};
      if (we && a == 3'(i)) m_cnt[i] = wd;
      else if (d != 0 && en && s >= THR) begin
        m_cnt[i] = 32'h8000_0000;
        nf[i] = 1'b1;
      end else m_cnt[i] = s[31:0];
    end
    m_irq   = (|nf) & m_c0[5];
    m_flags = nf;
    if (we && a == 3'd6) m_c0 = wd;
    if (we && a == 3'd7) m_c1 = wd;
    @(posedge clk);
    #1;
    check({tag, " R12 rdata"}, reg_rdata, exp_rd);
    check({tag, " R7 flags"}, {26'd0, ovf_flags}, {26'd0, m_flags});
    check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [31:0] d);
    step(tag, 3'd0, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic readall(string tag);
    for (int a = 0; a < 8; a++) step(tag, 3'd0, 1'b0, 1'b0, 1'b0, 3'(a), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; inst_cnt = 0; cyc_tick = 0; run_latch = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    m_c0 = 0; m_c1 = 0; m_flags = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset rdata", reg_rdata, 32'd0);
    check("R12 reset flags", {26'd0, ovf_flags}, 32'd0);
    check("R12 reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2/R3 select register zero: only counters 5 and 6 move
    for (int c = 0; c < 10; c++) step("R2 R3 idle", 3'(c % 5), c[0], 1'b1, 1'b0, 3'(c % 8), 0);
    readall("R3 fixed");

    // R4 R5 R6 R10: sweep every event code on counters 1-4
    for (int code = 0; code < 256; code++) begin
      wr("R4 sel", 3'd7, {8'(code), 8'(code), 8'(code), 8'(code ^ 8'h04)});
      for (int c = 0; c < 6; c++)
        step("R4 R5 R6 R10 sweep", 3'((c * 3 + code) % 5), c[0] ^ code[1],
             code[0] ^ c[1], 1'b0, 3'((c + code) % 8), 0);
    end
    wr("R6 sel", 3'd7, 32'h02_1E_1E_FA);
    for (int c = 0; c < 8; c++) step("R6 runlatch", 3'd3, 1'b1, c[1], 1'b0, 3'd3, 0);

    // R1 global freeze
    wr("R1 frz", 3'd6, 32'h1);
    for (int c = 0; c < 6; c++) step("R1 freeze", 3'd4, 1'b1, 1'b1, 1'b0, 3'(c), 0);
    // R2 selectable freeze
    wr("R2 frz", 3'd6, 32'h2);
    for (int c = 0; c < 6; c++) step("R2 freeze", 3'd4, 1'b1, 1'b1, 1'b0, 3'(c), 0);
    // R3 fixed freeze
    wr("R3 frz", 3'd6, 32'h4);
    for (int c = 0; c < 6; c++) step("R3 freeze", 3'd4, 1'b1, 1'b1, 1'b0, 3'(c), 0);

    // R7 R9 overflow with all enables and interrupt
    wr("R7 c0", 3'd6, 32'h38);
    wr("R7 c1", 3'd7, 32'h02_1E_02_FA);
    wr("R7 p1", 3'd0, 32'h7FFF_FFFE);
    wr("R7 p2", 3'd1, 32'h7FFF_FFFF);
    wr("R7 p3", 3'd2, 32'h7FFF_FFFC);
    wr("R7 p5", 3'd4, 32'h7FFF_FFFD);
    wr("R7 p6", 3'd5, 32'h7FFF_FFFF);
    for (int c = 0; c < 4; c++) step("R7 R9 ovf", 3'd4, 1'b1, 1'b1, 1'b0, 3'(c), 0);
    readall("R7 clamp");
    // R11 write in same cycle as a counting update
    step("R11 prio", 3'd4, 1'b1, 1'b1, 1'b1, 3'd4, 32'h7FFF_FFFF);
    step("R11 after", 3'd1, 1'b1, 1'b1, 1'b0, 3'd4, 0);
    // R9 interrupt disabled: flags only
    wr("R9 noirq", 3'd6, 32'h18);
    wr("R9 p5", 3'd4, 32'h7FFF_FFFE);
    for (int c = 0; c < 3; c++) step("R9 noirq", 3'd2, 1'b1, 1'b0, 1'b0, 3'd4, 0);
    // R8 only counter 1 enable: others wrap past the threshold
    wr("R8 c0", 3'd6, 32'h28);
    wr("R8 p1", 3'd0, 32'h7FFF_FFFE);
    wr("R8 p3", 3'd2, 32'h7FFF_FFFE);
    wr("R8 p5", 3'd4, 32'h7FFF_FFFE);
    for (int c = 0; c < 3; c++) step("R8 split", 3'd4, 1'b1, 1'b0, 1'b0, 3'(c * 2), 0);
    readall("R8 values");
    // R8 shared enable only
    wr("R8 c0b", 3'd6, 32'h30);
    wr("R8 p1b", 3'd0, 32'h7FFF_FFFF);
    wr("R8 p5b", 3'd4, 32'h7FFF_FFFF);
    for (int c = 0; c < 3; c++) step("R8 shared", 3'd4, 1'b1, 1'b0, 1'b0, 3'(c * 4), 0);
    // R7 wrap without enable
    wr("R7 noen", 3'd6, 32'h0);
    wr("R7 w1", 3'd0, 32'hFFFF_FFFE);
    wr("R7 w6", 3'd5, 32'hFFFF_FFFF);
    for (int c = 0; c < 3; c++) step("R7 wrap", 3'd4, 1'b1, 1'b0, 1'b0, 3'(c * 5), 0);
    // R11 control write effective next cycle
    step("R11 ctrl", 3'd4, 1'b1, 1'b0, 1'b1, 3'd6, 32'h1);
    step("R11 ctrl next", 3'd4, 1'b1, 1'b0, 1'b0, 3'd4, 0);
    readall("R11 final");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule